// File: doc/BRIEF.md
# L1 Line Coherence Controller (MOESI, directory-based)

This block is the state machine for one line of a private first-level cache. The cache sits in a directory-based coherence system that has an owned state. Each cycle it accepts at most one event. An event is a processor access, a request forwarded by the directory, a response from the network, or the all-acknowledgements trigger. For each event the controller decides four things in the same cycle: whether the event is served, whether it is refused (the head of its queue must be retried later), which request or response message goes out, and which state the line holds after the next clock edge.

After the line receives exclusive data, or after it completes a store upgrade, it enters a lockout copy of its modified state. The lockout lasts a fixed number of cycles, counted by a per-line use timer. During that window the line refuses replacements and every forwarded request, so the local processor is guaranteed some progress before it loses the line. Writebacks use separate transient states. These states cope with forwards that race the writeback and with refusals from the directory.

Top module: `l1_line_coherence`

## Requirements
- R1: During and after reset, line_state is I, perm is 0, req_type and rsp_type are 0, and done and stall are low. The state codes are I=0, S=1, O=2, M=3, M_W=4, MM=5, MM_W=6, IM=7, SM=8, OM=9, IS=10, SI=11, OI=12, MI=13, II=14.
- R2: An event is presented with evt_valid high. evt_code carries its code: load 0, ifetch 1, store 2, replace 3, forwarded shared read 4, forwarded exclusive read 5, DMA read 6, invalidate 7, own exclusive-read echo 8, writeback ack 9, writeback ack-with-data 10, writeback nack 11, ack 12, shared data 13, exclusive data 14, all-acks 15. Any pairing of a state and an event that no requirement names has no effect: the state is kept, no message is sent, and done and stall stay low.
- R3: In I, a load or ifetch moves the line to IS and sends request GETS (req_type 1). A store sends request GETX (req_type 2) and moves the line from I to IM, from S to SM, or from O to OM.
- R4: A load or ifetch raises done and keeps the state in S, O, M, M_W, MM, MM_W, SM and OM. A store raises done in MM and MM_W without a state change, in M with a move to MM, and in M_W with a move to MM_W.
- R5: Every transient state (codes 7 to 14) refuses stores and replacements. IM, IS, SI, OI, MI and II also refuse loads and ifetches. A refused event raises stall, sends nothing, does not raise done, and leaves the state unchanged.
- R6: In IS, shared data moves the line to S, raises done and sends UNBLOCK (rsp_type 4). Exclusive data moves it to M_W, raises done, sends EXCLUSIVE UNBLOCK (rsp_type 5) and starts the use timer.
- R7: M_W and MM_W refuse replacements and events 4 to 8. A lockout state lasts exactly USE_CYCLES cycles from its entry. lockout_expire is high in the last of those cycles. The line then moves from M_W to M, or from MM_W to MM. An event presented in the expiry cycle is refused.
- R8: A forwarded shared read sends DATA (rsp_type 1) in O, where the state is kept, and in M, where the line moves to O. In MM it sends EXCLUSIVE DATA (rsp_type 2) and the line moves to I. A forwarded exclusive read in O, M or MM sends EXCLUSIVE DATA and the line moves to I. A DMA read in O, M or MM sends DATA and keeps the state.
- R9: In IM or SM, either kind of data moves the line to OM. An invalidate sends ACK (rsp_type 3): in SM the line moves to IM, in IM it stays. In OM, a forwarded shared read sends DATA and keeps the state. A forwarded exclusive read in OM sends EXCLUSIVE DATA and the line falls back to IM. All-acks in OM raises done, sends EXCLUSIVE UNBLOCK, enters MM_W and starts the use timer.
- R10: An invalidate in I or S sends ACK and leaves the line in I.
- R11: A replacement in S sends PUTS (req_type 3) and moves the line to SI. In O it sends PUTO (req_type 4) and moves the line to OI. In M or MM it sends PUTX (req_type 5) and moves the line to MI. In I a replacement has no effect.
- R12: A forwarded shared read in MI sends DATA and the line moves to OI. In OI the same read sends DATA and the line stays. A forwarded exclusive read in MI or OI sends EXCLUSIVE DATA and the line moves to II. An invalidate in SI sends ACK and the line moves to II.
- R13: A writeback ack in SI, OI, MI or II moves the line to I with UNBLOCK. An ack-with-data in SI, OI or MI moves the line to I and sends WRITEBACK DATA (rsp_type 6). A nack in MI or OI sends PUTO and the line moves to OI. In SI a nack sends PUTS and the line stays in SI. In II a nack moves the line to I with no message.
- R14: perm is 2 (read-write) in MM and MM_W. It is 1 (read-only) in S, O, M, M_W, SM and OM, and 0 (none) in every other state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| evt_valid | input | 1 | An event is presented this cycle |
| evt_code | input | 4 | Event code (R2) |
| line_state | output | 4 | Current line state (R1 codes) |
| perm | output | 2 | Access permission of the current state |
| stall | output | 1 | The presented event is refused and must be retried |
| done | output | 1 | The presented processor access, or the finished miss, completes |
| req_type | output | 3 | Request message sent this cycle, 0 when none |
| rsp_type | output | 3 | Response message sent this cycle, 0 when none |
| lockout_expire | output | 1 | Last cycle of the use-timer lockout |

## Verification
Some properties are checked by assertions on every cycle:
- read-write permission appears only in the two locally-written states;
- a refused event sends nothing and freezes the state unless the timer expires in that cycle;
- lockout states refuse every forward and never outlast their window;
- an expiry always lands in M or MM.

The bench's scenarios are needed for the rest. It walks every state against every event and compares the result with an independent table. It measures the lockout window from entry to exit, and it presents a store in the very cycle of expiry. Only these scenarios show that each message code and destination state is right, and that the window is exactly as long as configured.

// File: rtl/l1_coh_pkg.sv
package l1_coh_pkg;

  typedef enum logic [3:0] {
    ST_I    = 4'd0,
    ST_S    = 4'd1,
    ST_O    = 4'd2,
    ST_M    = 4'd3,
    ST_M_W  = 4'd4,
    ST_MM   = 4'd5,
    ST_MM_W = 4'd6,
    ST_IM   = 4'd7,
    ST_SM   = 4'd8,
    ST_OM   = 4'd9,
    ST_IS   = 4'd10,
    ST_SI   = 4'd11,
    ST_OI   = 4'd12,
    ST_MI   = 4'd13,
    ST_II   = 4'd14
  } line_st_t;

  typedef enum logic [3:0] {
    EV_LOAD     = 4'd0,
    EV_IFETCH   = 4'd1,
    EV_STORE    = 4'd2,
    EV_REPLACE  = 4'd3,
    EV_FWD_SHR  = 4'd4,
    EV_FWD_EXC  = 4'd5,
    EV_FWD_DMA  = 4'd6,
    EV_INVAL    = 4'd7,
    EV_OWN_EXC  = 4'd8,
    EV_WB_ACK   = 4'd9,
    EV_WB_ACKD  = 4'd10,
    EV_WB_NACK  = 4'd11,
    EV_ACK      = 4'd12,
    EV_DATA_SHR = 4'd13,
    EV_DATA_EXC = 4'd14,
    EV_ALL_ACKS = 4'd15
  } evt_t;

  typedef enum logic [2:0] {
    RQ_NONE = 3'd0,
    RQ_GETS = 3'd1,
    RQ_GETX = 3'd2,
    RQ_PUTS = 3'd3,
    RQ_PUTO = 3'd4,
    RQ_PUTX = 3'd5
  } req_t;

  typedef enum logic [2:0] {
    RS_NONE     = 3'd0,
    RS_DATA     = 3'd1,
    RS_DATA_EX  = 3'd2,
    RS_ACK      = 3'd3,
    RS_UNBLK    = 3'd4,
    RS_UNBLK_EX = 3'd5,
    RS_WB_DATA  = 3'd6
  } rsp_t;

  localparam logic [1:0] PERM_NONE = 2'd0;
  localparam logic [1:0] PERM_RO   = 2'd1;
  localparam logic [1:0] PERM_RW   = 2'd2;

  function automatic logic in_lockout(input line_st_t s);
    return (s == ST_M_W) || (s == ST_MM_W);
  endfunction

  function automatic logic is_transient(input line_st_t s);
    return s >= ST_IM;
  endfunction

  function automatic logic refuses_reads(input line_st_t s);
    return (s == ST_IM) || (s == ST_IS) || (s == ST_SI) ||
           (s == ST_OI) || (s == ST_MI) || (s == ST_II);
  endfunction

  function automatic logic is_forward(input evt_t e);
    return (e >= EV_FWD_SHR) && (e <= EV_OWN_EXC);
  endfunction

  function automatic logic is_read(input evt_t e);
    return (e == EV_LOAD) || (e == EV_IFETCH);
  endfunction

  function automatic logic must_stall(input line_st_t s, input evt_t e);
    logic wr_or_rep;
    wr_or_rep = (e == EV_STORE) || (e == EV_REPLACE);
    return (is_transient(s) && wr_or_rep) ||
           (refuses_reads(s) && is_read(e)) ||
           (in_lockout(s) && ((e == EV_REPLACE) || is_forward(e)));
  endfunction

  function automatic logic [1:0] perm_of(input line_st_t s);
    case (s)
      ST_MM, ST_MM_W:                         return PERM_RW;
      ST_S, ST_O, ST_M, ST_M_W, ST_SM, ST_OM: return PERM_RO;
      default:                                return PERM_NONE;
    endcase
  endfunction

endpackage

// File: rtl/l1_use_timer.sv
module l1_use_timer
  import l1_coh_pkg::*;
#(
  parameter int USE_CYCLES = 50
) (
  input  logic clk,
  input  logic rst_n,
  input  logic arm,
  input  logic hold,
  output logic expire
);
  localparam int CW = $clog2(USE_CYCLES + 1);
  localparam logic [CW-1:0] LOAD_VAL = CW'(USE_CYCLES - 1);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt <= '0;
    end else if (arm) begin
      cnt <= LOAD_VAL;
    end else if (hold && (cnt != '0)) begin
      cnt <= cnt - 1'b1;
    end
  end

  assign expire = hold && (cnt == '0);
endmodule

// File: rtl/l1_perm_map.sv
module l1_perm_map
  import l1_coh_pkg::*;
(
  input  line_st_t   st,
  output logic [1:0] perm
);
  always_comb perm = perm_of(st);
endmodule

// File: rtl/l1_line_decode.sv
module l1_line_decode
  import l1_coh_pkg::*;
(
  input  line_st_t   st,
  input  logic       evt_valid,
  input  logic [3:0] evt_code,
  input  logic       expire,
  output line_st_t   nxt,
  output req_t       req,
  output rsp_t       rsp,
  output logic       done,
  output logic       stall,
  output logic       arm
);
  evt_t ev;
  assign ev = evt_t'(evt_code);

  always_comb begin
    nxt   = st;
    req   = RQ_NONE;
    rsp   = RS_NONE;
    done  = 1'b0;
    stall = 1'b0;
    arm   = 1'b0;
    if (expire) begin
      nxt   = (st == ST_MM_W) ? ST_MM : ST_M;
      stall = evt_valid;
    end else if (evt_valid) begin
      if (must_stall(st, ev)) begin
        stall = 1'b1;
      end else begin
        case (st)
          ST_I: begin
            case (ev)
              EV_LOAD, EV_IFETCH: begin nxt = ST_IS; req = RQ_GETS; end
              EV_STORE:           begin nxt = ST_IM; req = RQ_GETX; end
              EV_INVAL:           rsp = RS_ACK;
              default: ;
            endcase
          end
          ST_S: begin
            case (ev)
              EV_LOAD, EV_IFETCH: done = 1'b1;
              EV_STORE:   begin nxt = ST_SM; req = RQ_GETX; end
              EV_REPLACE: begin nxt = ST_SI; req = RQ_PUTS; end
              EV_INVAL:   begin nxt = ST_I;  rsp = RS_ACK;  end
              default: ;
            endcase
          end
          ST_O: begin
            case (ev)
              EV_LOAD, EV_IFETCH: done = 1'b1;
              EV_STORE:   begin nxt = ST_OM; req = RQ_GETX; end
              EV_REPLACE: begin nxt = ST_OI; req = RQ_PUTO; end
              EV_FWD_SHR, EV_FWD_DMA: rsp = RS_DATA;
              EV_FWD_EXC: begin nxt = ST_I; rsp = RS_DATA_EX; end
              default: ;
            endcase
          end
          ST_M: begin
            case (ev)
              EV_LOAD, EV_IFETCH: done = 1'b1;
              EV_STORE:   begin nxt = ST_MM; done = 1'b1; end
              EV_REPLACE: begin nxt = ST_MI; req = RQ_PUTX; end
              EV_FWD_SHR: begin nxt = ST_O;  rsp = RS_DATA; end
              EV_FWD_EXC: begin nxt = ST_I;  rsp = RS_DATA_EX; end
              EV_FWD_DMA: rsp = RS_DATA;
              default: ;
            endcase
          end
          ST_MM: begin
            case (ev)
              EV_LOAD, EV_IFETCH, EV_STORE: done = 1'b1;
              EV_REPLACE: begin nxt = ST_MI; req = RQ_PUTX; end
              EV_FWD_SHR, EV_FWD_EXC: begin nxt = ST_I; rsp = RS_DATA_EX; end
              EV_FWD_DMA: rsp = RS_DATA;
              default: ;
            endcase
          end
          ST_M_W: begin
            case (ev)
              EV_LOAD, EV_IFETCH: done = 1'b1;
              EV_STORE: begin nxt = ST_MM_W; done = 1'b1; end
              default: ;
            endcase
          end
          ST_MM_W: begin
            case (ev)
              EV_LOAD, EV_IFETCH, EV_STORE: done = 1'b1;
              default: ;
            endcase
          end
          ST_IM, ST_SM: begin
            case (ev)
              EV_LOAD, EV_IFETCH: done = (st == ST_SM);
              EV_DATA_SHR, EV_DATA_EXC: nxt = ST_OM;
              EV_INVAL: begin nxt = ST_IM; rsp = RS_ACK; end
              default: ;
            endcase
          end
          ST_OM: begin
            case (ev)
              EV_LOAD, EV_IFETCH: done = 1'b1;
              EV_FWD_SHR: rsp = RS_DATA;
              EV_FWD_EXC: begin nxt = ST_IM; rsp = RS_DATA_EX; end
              EV_ALL_ACKS: begin
                nxt  = ST_MM_W;
                rsp  = RS_UNBLK_EX;
                done = 1'b1;
                arm  = 1'b1;
              end
              default: ;
            endcase
          end
          ST_IS: begin
            case (ev)
              EV_DATA_SHR: begin nxt = ST_S; rsp = RS_UNBLK; done = 1'b1; end
              EV_DATA_EXC: begin
                nxt  = ST_M_W;
                rsp  = RS_UNBLK_EX;
                done = 1'b1;
                arm  = 1'b1;
              end
              default: ;
            endcase
          end
          ST_SI: begin
            case (ev)
              EV_INVAL:   begin nxt = ST_II; rsp = RS_ACK; end
              EV_WB_ACK:  begin nxt = ST_I;  rsp = RS_UNBLK; end
              EV_WB_ACKD: begin nxt = ST_I;  rsp = RS_WB_DATA; end
              EV_WB_NACK: req = RQ_PUTS;
              default: ;
            endcase
          end
          ST_OI, ST_MI: begin
            case (ev)
              EV_FWD_SHR: begin nxt = ST_OI; rsp = RS_DATA; end
              EV_FWD_EXC: begin nxt = ST_II; rsp = RS_DATA_EX; end
              EV_WB_ACK:  begin nxt = ST_I;  rsp = RS_UNBLK; end
              EV_WB_ACKD: begin nxt = ST_I;  rsp = RS_WB_DATA; end
              EV_WB_NACK: begin nxt = ST_OI; req = RQ_PUTO; end
              default: ;
            endcase
          end
          ST_II: begin
            case (ev)
              EV_WB_ACK:  begin nxt = ST_I; rsp = RS_UNBLK; end
              EV_WB_NACK: nxt = ST_I;
              default: ;
            endcase
          end
          default: ;
        endcase
      end
    end
  end
endmodule

// File: rtl/l1_line_coherence.sv
module l1_line_coherence
  import l1_coh_pkg::*;
#(
  parameter int USE_CYCLES = 50
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       evt_valid,
  input  logic [3:0] evt_code,
  output logic [3:0] line_state,
  output logic [1:0] perm,
  output logic       stall,
  output logic       done,
  output logic [2:0] req_type,
  output logic [2:0] rsp_type,
  output logic       lockout_expire
);
  line_st_t st_q;
  line_st_t st_nxt;
  req_t     req_w;
  rsp_t     rsp_w;
  logic     arm_w;
  logic     hold_w;
  logic     expire_w;

  assign hold_w = in_lockout(st_q);

  l1_use_timer #(.USE_CYCLES(USE_CYCLES)) u_timer (
    .clk    (clk),
    .rst_n  (rst_n),
    .arm    (arm_w),
    .hold   (hold_w),
    .expire (expire_w)
  );

  l1_line_decode u_decode (
    .st        (st_q),
    .evt_valid (evt_valid),
    .evt_code  (evt_code),
    .expire    (expire_w),
    .nxt       (st_nxt),
    .req       (req_w),
    .rsp       (rsp_w),
    .done      (done),
    .stall     (stall),
    .arm       (arm_w)
  );

  l1_perm_map u_perm (
    .st   (st_q),
    .perm (perm)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) st_q <= ST_I;
    else        st_q <= st_nxt;
  end

  assign line_state     = st_q;
  assign req_type       = req_w;
  assign rsp_type       = rsp_w;
  assign lockout_expire = expire_w;
endmodule

// File: rtl/l1_line_coherence_chk.sv
module l1_line_coherence_chk
  import l1_coh_pkg::*;
#(
  parameter int USE_CYCLES = 50
) (
  input logic       clk,
  input logic       rst_n,
  input logic       evt_valid,
  input logic [3:0] evt_code,
  input logic [3:0] line_state,
  input logic [1:0] perm,
  input logic       stall,
  input logic       done,
  input logic [2:0] req_type,
  input logic [2:0] rsp_type,
  input logic       lockout_expire
);
  logic locked;
  int   run;

  assign locked = (line_state == 4'(ST_M_W)) || (line_state == 4'(ST_MM_W));

  always_ff @(posedge clk) begin
    if (!rst_n)      run <= 0;
    else if (locked) run <= run + 1;
    else             run <= 0;
  end

  // R14
  rw_perm_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (perm == 2'd2) |-> (line_state == 4'(ST_MM) || line_state == 4'(ST_MM_W)));

  // R5
  stall_freeze_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (stall && !lockout_expire) |=> (line_state == $past(line_state)));

  // R5
  stall_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    stall |-> (req_type == 3'd0 && rsp_type == 3'd0 && !done));

  // R7
  expire_exit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    lockout_expire |=> (line_state == 4'(ST_M) || line_state == 4'(ST_MM)));

  // R7
  lock_fwd_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (evt_valid && locked && evt_code >= 4'd3 && evt_code <= 4'd8) |-> stall);

  // R7
  lock_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
    locked |-> (run < USE_CYCLES));

  // R6
  is_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (line_state == 4'(ST_IS) && evt_valid && evt_code == 4'd14 && !lockout_expire)
      |=> (line_state == 4'(ST_M_W)));
endmodule

bind l1_line_coherence l1_line_coherence_chk #(.USE_CYCLES(USE_CYCLES)) u_chk (
  .clk            (clk),
  .rst_n          (rst_n),
  .evt_valid      (evt_valid),
  .evt_code       (evt_code),
  .line_state     (line_state),
  .perm           (perm),
  .stall          (stall),
  .done           (done),
  .req_type       (req_type),
  .rsp_type       (rsp_type),
  .lockout_expire (lockout_expire)
);

// File: tb/l1_line_coherence_test.sv
`timescale 1ns/1ps
module l1_line_coherence_test;
  localparam int LOCK = 50;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       evt_valid = 1'b0;
  logic [3:0] evt_code = 4'd0;
  logic [3:0] line_state;
  logic [1:0] perm;
  logic       stall;
  logic       done;
  logic [2:0] req_type;
  logic [2:0] rsp_type;
  logic       lockout_expire;

  int checks = 0;
  int fails = 0;
  bit finished = 0;
  int o_req, o_rsp, o_done, o_stall;

  typedef struct packed {
    logic [3:0] nx;
    logic [2:0] rq;
    logic [2:0] rs;
    logic       dn;
    logic       sl;
  } exp_t;

  always #2.5 clk = ~clk;

  l1_line_coherence #(.USE_CYCLES(LOCK)) uut (
    .clk(clk), .rst_n(rst_n), .evt_valid(evt_valid), .evt_code(evt_code),
    .line_state(line_state), .perm(perm), .stall(stall), .done(done),
    .req_type(req_type), .rsp_type(rsp_type), .lockout_expire(lockout_expire)
  );

  task automatic chk(input string tag, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s: actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    evt_valid = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
  endtask

  // called at a falling edge; returns at the next falling edge
  task automatic apply(input int ev);
    evt_valid = 1'b1;
    evt_code = 4'(ev);
    #1;
    o_req = req_type; o_rsp = rsp_type; o_done = done; o_stall = stall;
    @(negedge clk);
    evt_valid = 1'b0;
  endtask

  task automatic settle();
    for (int i = 0; i < LOCK + 5 && (line_state == 4'd4 || line_state == 4'd6); i++)
      @(negedge clk);
  endtask

  task automatic goto(input int s);
    do_reset();
    case (s)
      1:  begin apply(0); apply(13); end
      2:  begin apply(0); apply(14); settle(); apply(4); end
      3:  begin apply(0); apply(14); settle(); end
      4:  begin apply(0); apply(14); end
      5:  begin apply(0); apply(14); apply(2); settle(); end
      6:  begin apply(0); apply(14); apply(2); end
      7:  apply(2);
      8:  begin apply(0); apply(13); apply(2); end
      9:  begin apply(2); apply(13); end
      10: apply(0);
      11: begin apply(0); apply(13); apply(3); end
      12: begin apply(0); apply(14); settle(); apply(4); apply(3); end
      13: begin apply(0); apply(14); settle(); apply(3); end
      14: begin apply(0); apply(13); apply(3); apply(7); end
      default: ;
    endcase
  endtask

  function automatic string path_tag(input int s);
    case (s)
      0: return "R1";
      1, 4: return "R6";
      3, 5: return "R7";
      6: return "R4";
      2: return "R8";
      9: return "R9";
      11, 12, 13: return "R11";
      14: return "R12";
      default: return "R3";
    endcase
  endfunction

  function automatic int perm_exp(input int s);
    if (s == 5 || s == 6) return 2;                    // R14 read-write
    if (s inside {1, 2, 3, 4, 8, 9}) return 1;         // R14 read-only
    return 0;
  endfunction

  // Expected reaction of a line in state s to event e, from the requirements
  function automatic exp_t model(input int s, input int e);
    exp_t x;
    bit tr, noread, lk;
    x = '{nx: 4'(s), rq: 3'd0, rs: 3'd0, dn: 1'b0, sl: 1'b0};
    tr = (s >= 7);
    noread = s inside {7, 10, 11, 12, 13, 14};
    lk = (s == 4 || s == 6);
    if ((e == 2 || e == 3) && tr) x.sl = 1'b1;                  // R5
    else if (e <= 1 && noread) x.sl = 1'b1;                     // R5
    else if (lk && e >= 3 && e <= 8) x.sl = 1'b1;               // R7
    else begin
      case (e)
        0, 1: begin
          if (s == 0) begin x.nx = 4'd10; x.rq = 3'd1; end      // R3
          else if (s inside {1, 2, 3, 4, 5, 6, 8, 9}) x.dn = 1; // R4
        end
        2: case (s)                                              // R3 / R4
          0: begin x.nx = 4'd7; x.rq = 3'd2; end
          1: begin x.nx = 4'd8; x.rq = 3'd2; end
          2: begin x.nx = 4'd9; x.rq = 3'd2; end
          3: begin x.nx = 4'd5; x.dn = 1; end
          4: begin x.nx = 4'd6; x.dn = 1; end
          5, 6: x.dn = 1;
          default: ;
        endcase
        3: case (s)                                              // R11
          1: begin x.nx = 4'd11; x.rq = 3'd3; end
          2: begin x.nx = 4'd12; x.rq = 3'd4; end
          3, 5: begin x.nx = 4'd13; x.rq = 3'd5; end
          default: ;
        endcase
        4: case (s)                                              // R8 / R9 / R12
          2, 9, 12: x.rs = 3'd1;
          3: begin x.nx = 4'd2; x.rs = 3'd1; end
          5: begin x.nx = 4'd0; x.rs = 3'd2; end
          13: begin x.nx = 4'd12; x.rs = 3'd1; end
          default: ;
        endcase
        5: case (s)
          2, 3, 5: begin x.nx = 4'd0; x.rs = 3'd2; end
          9: begin x.nx = 4'd7; x.rs = 3'd2; end
          12, 13: begin x.nx = 4'd14; x.rs = 3'd2; end
          default: ;
        endcase
        6: if (s inside {2, 3, 5}) x.rs = 3'd1;
        7: case (s)                                              // R10 / R9 / R12
          0, 1: begin x.nx = 4'd0; x.rs = 3'd3; end
          7: x.rs = 3'd3;
          8: begin x.nx = 4'd7; x.rs = 3'd3; end
          11: begin x.nx = 4'd14; x.rs = 3'd3; end
          default: ;
        endcase
        9: if (s >= 11) begin x.nx = 4'd0; x.rs = 3'd4; end     // R13
        10: if (s >= 11 && s <= 13) begin x.nx = 4'd0; x.rs = 3'd6; end
        11: case (s)
          11: x.rq = 3'd3;
          12, 13: begin x.nx = 4'd12; x.rq = 3'd4; end
          14: x.nx = 4'd0;
          default: ;
        endcase
        13: if (s == 10) begin x.nx = 4'd1; x.rs = 3'd4; x.dn = 1; end // R6
            else if (s == 7 || s == 8) x.nx = 4'd9;                     // R9
        14: if (s == 10) begin x.nx = 4'd4; x.rs = 3'd5; x.dn = 1; end
            else if (s == 7 || s == 8) x.nx = 4'd9;
        15: if (s == 9) begin x.nx = 4'd6; x.rs = 3'd5; x.dn = 1; end // R9
        default: ;                                               // R2 ignored
      endcase
    end
    return x;
  endfunction

  function automatic string ev_tag(input int s, input int e, input exp_t x);
    if (x.sl) return ((s == 4 || s == 6) ? "R7" : "R5");
    if (e <= 2) return "R3/R4";
    if (e == 3) return "R11";
    if (e >= 4 && e <= 6) return (s >= 11) ? "R12" : "R8";
    if (e == 7) return (s <= 1) ? "R10" : "R9/R12";
    if (e >= 9 && e <= 11) return "R13";
    if (e == 13 || e == 14) return (s == 10) ? "R6" : "R9";
    if (e == 15) return "R9";
    return "R2";
  endfunction

  initial begin
    #(200000.0 * 5.0);
    if (!finished) begin
      checks++;
      fails++;
      $display("FAIL watchdog expired: actual=1 expected=0");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    exp_t x;
    int n, ex_cnt, ex_pos;
    @(negedge clk);
    // R1 reset state
    chk("R1", "state in reset", line_state, 0);
    chk("R1", "perm in reset", perm, 0);
    do_reset();
    chk("R1", "state after reset", line_state, 0);
    chk("R1", "req after reset", req_type, 0);
    chk("R1", "rsp after reset", rsp_type, 0);
    chk("R1", "stall after reset", stall, 0);
    chk("R1", "done after reset", done, 0);

    // R2..R14 near-exhaustive state x event sweep
    for (int s = 0; s < 15; s++) begin
      for (int e = 0; e < 16; e++) begin
        goto(s);
        chk(path_tag(s), "reached state", line_state, s);
        if (e == 0) chk("R14", "perm", perm, perm_exp(s));
        x = model(s, e);
        apply(e);
        chk(ev_tag(s, e, x), $sformatf("s%0d e%0d stall", s, e), o_stall, x.sl);
        chk(ev_tag(s, e, x), $sformatf("s%0d e%0d done", s, e), o_done, x.dn);
        chk(ev_tag(s, e, x), $sformatf("s%0d e%0d req", s, e), o_req, x.rq);
        chk(ev_tag(s, e, x), $sformatf("s%0d e%0d rsp", s, e), o_rsp, x.rs);
        chk(ev_tag(s, e, x), $sformatf("s%0d e%0d next", s, e), line_state, x.nx);
      end
    end

    // R7 lockout window length, from M_W and from MM_W
    for (int v = 0; v < 2; v++) begin
      do_reset();
      if (v == 0) begin apply(0); apply(14); end
      else begin apply(2); apply(13); apply(15); end
      n = 0; ex_cnt = 0; ex_pos = 0;
      while ((line_state == 4'd4 || line_state == 4'd6) && n < LOCK + 10) begin
        n++;
        if (lockout_expire) begin ex_cnt++; ex_pos = n; end
        @(negedge clk);
      end
      chk("R7", "lockout cycles", n, LOCK);
      chk("R7", "expire pulses", ex_cnt, 1);
      chk("R7", "expire cycle", ex_pos, LOCK);
      chk("R7", "state after lockout", line_state, (v == 0) ? 3 : 5);
      chk("R14", "perm after lockout", perm, (v == 0) ? 1 : 2);
    end

    // R7 store presented in the expiry cycle is refused
    do_reset();
    apply(0); apply(14);
    for (int i = 0; i < LOCK + 5 && !lockout_expire; i++) @(negedge clk);
    chk("R7", "expiry reached", lockout_expire, 1);
    evt_valid = 1'b1; evt_code = 4'd2;
    #1;
    chk("R7", "stall at expiry", stall, 1);
    chk("R7", "no done at expiry", done, 0);
    @(negedge clk);
    evt_valid = 1'b0;
    chk("R7", "state after expiry collision", line_state, 3);

    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule